// File: doc/BRIEF.md
# Programmable Video Memory Slot Scheduler

This block divides access to four video memory sub-banks between background-layer fetch units and a host CPU. Ownership is decided by a time-division table written by software, not by requests. Each sub-bank has a 32-bit table holding eight 4-bit slot commands. A slot counter walks the slots T0 to T7 while the display is active. In each slot, every sub-bank's command is decoded into a one-hot grant for a requester class plus a layer number. The classes are name-table read, character read, column-scroll table read, CPU and idle.

Software writes tables into a staging copy. The staging copy moves into the working copy only at a T0 boundary, so the fetch units never see half of one pattern and half of another. When the memory is not split, the tables of sub-banks 0 and 2 drive both halves of banks A and B. During blanking every sub-bank belongs to the CPU. A CPU request waits until a slot on its sub-bank grants CPU access, and it is acknowledged in that slot.

The sequencer has two states. In `ST_BLANK` the slot counter is held at 0 and the tables reload every cycle. In `ST_ACTIVE` the slot counter steps each cycle. The "display start" transition goes from `ST_BLANK` to `ST_ACTIVE` when `disp_active` is sampled high. The "display end" transition goes from `ST_ACTIVE` to `ST_BLANK` when `disp_active` is sampled low, even in the middle of a group.

Top module: `vram_slot_sched`

## Requirements
- R1: After reset the block is in `ST_BLANK` with `slot_idx` = 0, and every table holds 0xFFFFFFFF, so a display group started without any write grants nothing in any slot.
- R2: On the first clock edge where `disp_active` is high in `ST_BLANK`, the block enters `ST_ACTIVE` at T0. It then advances one slot per clock, from T7 back to T0, for as long as `disp_active` stays high.
- R3: In slot Tn a sub-bank decodes bits [31-4n:28-4n] of its working table (T0 is the top nibble). Codes 0x0-0x3 select a name-table read for layers 0-3, codes 0x4-0x7 a character read for layers 0-3, and codes 0x8-0xB a column-scroll read for layers 0-3. Code 0xE selects the CPU. Codes 0xC, 0xD and 0xF grant nothing. `gnt_layer` is 0 for CPU and for no-grant slots.
- R4: For each sub-bank, at most one of `gnt_pn`, `gnt_cg`, `gnt_cs` and `gnt_cpu` is high in any cycle.
- R5: A table write (address 0=A0, 1=A1, 2=B0, 3=B1) has no effect on the group in progress. It takes effect from the next T0. This includes a write clocked in on the T7-to-T0 edge.
- R6: `split_en` is taken at the same boundary as the tables. When it is 0, sub-banks 1 and 3 give the same outputs as sub-banks 0 and 2.
- R7: In `ST_BLANK` every sub-bank has `gnt_cpu` high, all other grants low and layer 0, whatever the tables hold.
- R8: `cpu_ack` is high exactly when `cpu_req` is high and the sub-bank addressed by `cpu_bank` has `gnt_cpu` high in the current cycle.
- R9: On the first edge where `disp_active` is low, the block returns to `ST_BLANK` with `slot_idx` = 0, even mid-group. The next display start begins again at T0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_addr | input | 2 | Table select: 0=A0, 1=A1, 2=B0, 3=B1 |
| cfg_wdata | input | 32 | Table value, T0 in bits [31:28] |
| split_en | input | 1 | 1: four independent tables; 0: A0/B0 tables govern whole banks |
| disp_active | input | 1 | High during the active display period |
| cpu_req | input | 1 | CPU access request |
| cpu_bank | input | 2 | Sub-bank addressed by the CPU |
| cpu_ack | output | 1 | CPU access granted in this cycle |
| slot_idx | output | 3 | Current slot number |
| gnt_pn | output | 4 | Per sub-bank name-table read grant |
| gnt_cg | output | 4 | Per sub-bank character read grant |
| gnt_cs | output | 4 | Per sub-bank column-scroll read grant |
| gnt_cpu | output | 4 | Per sub-bank CPU grant |
| gnt_layer | output | 8 | Per sub-bank layer number, 2 bits each, sub-bank b at [2b+1:2b] |

## Verification
The hardest case to reach from the ports is a table write that lands on the exact edge where the working copy reloads. That is the T7-to-T0 edge, where a staged value and a new write compete. The bench counts slots from the display start and raises the write strobe while T7 is showing. It then checks that the very next T0 already decodes the new value. A second write, raised at T3, checks that slots T4 to T7 keep the old pattern.

// File: rtl/vss_pkg.sv
package vss_pkg;
    localparam int SLOTS  = 8;
    localparam int CMD_W  = 4;
    localparam int BANKS  = 4;
    localparam int LYR_W  = 2;
    localparam int TBL_W  = SLOTS * CMD_W;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int ADDR_W = $clog2(BANKS);

    typedef enum logic [2:0] {
        CL_NONE,
        CL_PN,
        CL_CG,
        CL_CS,
        CL_CPU
    } acc_class_e;

    typedef struct packed {
        acc_class_e       cls;
        logic [LYR_W-1:0] layer;
    } slot_cmd_t;

    typedef enum logic {
        ST_BLANK,
        ST_ACTIVE
    } seq_state_e;

    localparam logic [CMD_W-1:0] CODE_CPU = 4'hE;

    function automatic slot_cmd_t decode_cmd(input logic [CMD_W-1:0] code);
        slot_cmd_t r;
        r.layer = code[LYR_W-1:0];
        unique case (code[CMD_W-1:LYR_W])
            2'b00:   r.cls = CL_PN;
            2'b01:   r.cls = CL_CG;
            2'b10:   r.cls = CL_CS;
            default: begin
                r.cls   = (code == CODE_CPU) ? CL_CPU : CL_NONE;
                r.layer = '0;
            end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/vss_cfg_regs.sv
module vss_cfg_regs
    import vss_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [TBL_W-1:0]              wr_data,
    input  logic                          split_in,
    input  logic                          load,
    output logic [BANKS-1:0][TBL_W-1:0]   act_tbl,
    output logic                          act_split
);
    logic [BANKS-1:0][TBL_W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else if (wr_en) begin
            stg_q[wr_addr] <= wr_data;
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_act
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_tbl[b] <= '1;
            end else if (load) begin
                act_tbl[b] <= (wr_en && (wr_addr == ADDR_W'(b))) ? wr_data : stg_q[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_split <= 1'b1;
        end else if (load) begin
            act_split <= split_in;
        end
    end
endmodule

// File: rtl/vss_slot_seq.sv
module vss_slot_seq
    import vss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_en,
    output logic              in_disp,
    output logic [SLOT_W-1:0] slot,
    output logic              load
);
    seq_state_e        st_q, st_d;
    logic [SLOT_W-1:0] slot_q, slot_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_BLANK;
            slot_q <= '0;
        end else begin
            st_q   <= st_d;
            slot_q <= slot_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        slot_d = '0;
        unique case (st_q)
            ST_BLANK: begin
                if (disp_en) st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!disp_en) begin
                    st_d = ST_BLANK;
                end else if (slot_q != SLOT_W'(SLOTS - 1)) begin
                    slot_d = slot_q + SLOT_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        in_disp = (st_q == ST_ACTIVE);
        slot    = slot_q;
        load    = (st_q == ST_BLANK) || (slot_q == SLOT_W'(SLOTS - 1));
    end
endmodule

// File: rtl/vss_bank_decode.sv
module vss_bank_decode
    import vss_pkg::*;
(
    input  logic [TBL_W-1:0]  tbl,
    input  logic [SLOT_W-1:0] slot,
    input  logic              in_disp,
    output logic              pn,
    output logic              cg,
    output logic              cs,
    output logic              cpu,
    output logic [LYR_W-1:0]  layer
);
    logic [CMD_W-1:0] code;
    slot_cmd_t        dec;

    always_comb begin
        code = '1;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot == SLOT_W'(s)) code = tbl[(SLOTS - 1 - s) * CMD_W +: CMD_W];
        end
        dec = decode_cmd(code);
    end

    always_comb begin
        pn    = 1'b0;
        cg    = 1'b0;
        cs    = 1'b0;
        cpu   = 1'b0;
        layer = '0;
        if (!in_disp) begin
            cpu = 1'b1;
        end else begin
            unique case (dec.cls)
                CL_PN:   pn  = 1'b1;
                CL_CG:   cg  = 1'b1;
                CL_CS:   cs  = 1'b1;
                CL_CPU:  cpu = 1'b1;
                default: ;
            endcase
            layer = dec.layer;
        end
    end
endmodule

// File: rtl/vram_slot_sched.sv
module vram_slot_sched
    import vss_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr_en,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [TBL_W-1:0]         cfg_wdata,
    input  logic                     split_en,
    input  logic                     disp_active,
    input  logic                     cpu_req,
    input  logic [ADDR_W-1:0]        cpu_bank,
    output logic                     cpu_ack,
    output logic [SLOT_W-1:0]        slot_idx,
    output logic [BANKS-1:0]         gnt_pn,
    output logic [BANKS-1:0]         gnt_cg,
    output logic [BANKS-1:0]         gnt_cs,
    output logic [BANKS-1:0]         gnt_cpu,
    output logic [BANKS*LYR_W-1:0]   gnt_layer
);
    logic                        in_disp;
    logic                        load;
    logic                        act_split;
    logic [BANKS-1:0][TBL_W-1:0] act_tbl;

    vss_slot_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .disp_en (disp_active),
        .in_disp (in_disp),
        .slot    (slot_idx),
        .load    (load)
    );

    vss_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_addr   (cfg_addr),
        .wr_data   (cfg_wdata),
        .split_in  (split_en),
        .load      (load),
        .act_tbl   (act_tbl),
        .act_split (act_split)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam int PAIR = b - (b % 2);
        logic [TBL_W-1:0] eff_tbl;

        assign eff_tbl = act_split ? act_tbl[b] : act_tbl[PAIR];

        vss_bank_decode u_dec (
            .tbl     (eff_tbl),
            .slot    (slot_idx),
            .in_disp (in_disp),
            .pn      (gnt_pn[b]),
            .cg      (gnt_cg[b]),
            .cs      (gnt_cs[b]),
            .cpu     (gnt_cpu[b]),
            .layer   (gnt_layer[b*LYR_W +: LYR_W])
        );
    end

    assign cpu_ack = cpu_req && gnt_cpu[cpu_bank];
endmodule

// File: rtl/vss_chk.sv
module vss_chk
    import vss_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_disp,
    input logic [SLOT_W-1:0]           slot,
    input logic [BANKS-1:0][TBL_W-1:0] act_tbl,
    input logic                        act_split,
    input logic [BANKS-1:0]            gnt_pn,
    input logic [BANKS-1:0]            gnt_cg,
    input logic [BANKS-1:0]            gnt_cs,
    input logic [BANKS-1:0]            gnt_cpu,
    input logic [BANKS*LYR_W-1:0]      gnt_layer,
    input logic                        cpu_req,
    input logic [ADDR_W-1:0]           cpu_bank,
    input logic                        cpu_ack
);
    for (genvar b = 0; b < BANKS; b++) begin : g_oh
        AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({gnt_pn[b], gnt_cg[b], gnt_cs[b], gnt_cpu[b]})); // R4
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n) in_disp |=> (!in_disp || slot == $past(slot) + SLOT_W'(1))); // R2

    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (in_disp && slot != '0) |-> $stable(act_tbl)); // R5

    AST_UNSPLIT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n) (in_disp && !act_split) |-> ({gnt_pn[1], gnt_cg[1], gnt_cs[1], gnt_cpu[1], gnt_layer[3:2], gnt_pn[3], gnt_cg[3], gnt_cs[3], gnt_cpu[3], gnt_layer[7:6]} == {gnt_pn[0], gnt_cg[0], gnt_cs[0], gnt_cpu[0], gnt_layer[1:0], gnt_pn[2], gnt_cg[2], gnt_cs[2], gnt_cpu[2], gnt_layer[5:4]})); // R6

    AST_BLANK_CPU: assert property (@(posedge clk) disable iff (!rst_n) !in_disp |-> (gnt_cpu == '1 && gnt_pn == '0 && gnt_cg == '0 && gnt_cs == '0)); // R7

    AST_ACK_GRANT: assert property (@(posedge clk) disable iff (!rst_n) cpu_ack |-> (cpu_req && gnt_cpu[cpu_bank])); // R8

    AST_BLANK_SLOT0: assert property (@(posedge clk) disable iff (!rst_n) !in_disp |-> slot == '0); // R9
endmodule

bind vram_slot_sched vss_chk u_vss_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_disp   (in_disp),
    .slot      (slot_idx),
    .act_tbl   (act_tbl),
    .act_split (act_split),
    .gnt_pn    (gnt_pn),
    .gnt_cg    (gnt_cg),
    .gnt_cs    (gnt_cs),
    .gnt_cpu   (gnt_cpu),
    .gnt_layer (gnt_layer),
    .cpu_req   (cpu_req),
    .cpu_bank  (cpu_bank),
    .cpu_ack   (cpu_ack)
);

// File: tb/vram_slot_sched_test.sv
module vram_slot_sched_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        split_en = 1'b1;
    logic        disp_active = 1'b0;
    logic        cpu_req = 1'b0;
    logic [1:0]  cpu_bank = '0;
    logic        cpu_ack;
    logic [2:0]  slot_idx;
    logic [3:0]  gnt_pn, gnt_cg, gnt_cs, gnt_cpu;
    logic [7:0]  gnt_layer;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] mt [4];
    bit          ms;

    always #(CLK_P/2) clk = ~clk;

    vram_slot_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .split_en(split_en), .disp_active(disp_active),
        .cpu_req(cpu_req), .cpu_bank(cpu_bank), .cpu_ack(cpu_ack),
        .slot_idx(slot_idx), .gnt_pn(gnt_pn), .gnt_cg(gnt_cg), .gnt_cs(gnt_cs),
        .gnt_cpu(gnt_cpu), .gnt_layer(gnt_layer)
    );

    // {pn, cg, cs, cpu, layer[1:0]}
    function automatic logic [5:0] exp_bits(input logic [3:0] n, input bit disp);
        if (!disp) return 6'b000100;
        case (n[3:2])
            2'd0:    return {4'b1000, n[1:0]};
            2'd1:    return {4'b0100, n[1:0]};
            2'd2:    return {4'b0010, n[1:0]};
            default: return (n == 4'hE) ? 6'b000100 : 6'b000000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_now(input string tag, input int es, input bit disp);
        logic [5:0] e [4];
        for (int b = 0; b < 4; b++) begin
            logic [31:0] eff;
            logic [5:0]  got;
            eff  = ms ? mt[b] : mt[b & 2];
            e[b] = exp_bits(eff[(7 - es) * 4 +: 4], disp);
            got  = {gnt_pn[b], gnt_cg[b], gnt_cs[b], gnt_cpu[b], gnt_layer[2*b +: 2]};
            chk($sformatf("%s bank%0d slot%0d", tag, b, es), 32'(got), 32'(e[b]));
        end
        chk({tag, " slot_idx"}, 32'(slot_idx), 32'(es));
        chk({tag, " R8 cpu_ack"}, 32'(cpu_ack), 32'(cpu_req && e[cpu_bank][2]));
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        mt[a] = d;
    endtask

    task automatic end_display(input string tag);
        disp_active = 1'b0;
        @(negedge clk);
        check_now(tag, 0, 0);
    endtask

    task automatic t_reset();
        for (int b = 0; b < 4; b++) mt[b] = 32'hFFFF_FFFF;
        ms = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now("R1 R7 reset blank", 0, 0);
        disp_active = 1'b1;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R1 reset tables idle", s, 1);
        end
        end_display("R9 leave display");
    endtask

    task automatic t_decode();
        split_en = 1'b1; ms = 1'b1;
        wr(2'd0, 32'h0123_4567);
        wr(2'd1, 32'h89AB_CDEF);
        wr(2'd2, 32'h4455_F667);
        wr(2'd3, 32'hE5E5_FFDC);
        @(negedge clk);
        check_now("R7 blank ignores tables", 0, 0);
        disp_active = 1'b1;
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                check_now("R2 R3 decode", s, 1);
            end
        end
        end_display("R9 leave display");
    endtask

    task automatic t_unsplit();
        split_en = 1'b0; ms = 1'b0;
        @(negedge clk);
        disp_active = 1'b1;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R6 unsplit mirror", s, 1);
        end
        end_display("R9 leave display");
        split_en = 1'b1; ms = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_midgroup();
        logic [31:0] old_v;
        old_v = mt[0];
        disp_active = 1'b1;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R5 group before write", s, 1);
            if (s == 3) begin
                cfg_wr_en = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h8899_AABB;
            end
            if (s == 4) cfg_wr_en = 1'b0;
            if (s == 7) mt[0] = 32'h8899_AABB;
        end
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R5 applied at T0", s, 1);
            if (s == 7) begin
                cfg_wr_en = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h3210_7654;
                mt[0] = 32'h3210_7654;
            end
        end
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R5 write on T7 edge", s, 1);
            if (s == 0) cfg_wr_en = 1'b0;
        end
        if (old_v == mt[0]) chk("R5 value changed", 0, 1);
        end_display("R9 leave display");
    endtask

    task automatic t_cpu();
        wr(2'd1, 32'hFEFF_FFEF);
        wr(2'd2, 32'h0000_0000);
        cpu_req = 1'b1; cpu_bank = 2'd1;
        @(negedge clk);
        check_now("R8 ack in blank", 0, 0);
        disp_active = 1'b1;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R8 cpu wait bank1", s, 1);
        end
        cpu_bank = 2'd2;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R8 no cpu slot bank2", s, 1);
        end
        cpu_req = 1'b0; cpu_bank = 2'd1;
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            check_now("R8 no request", s, 1);
        end
        end_display("R9 leave display");
    endtask

    task automatic t_abort();
        disp_active = 1'b1;
        for (int s = 0; s < 5; s++) begin
            @(negedge clk);
            check_now("R2 partial group", s, 1);
        end
        end_display("R9 mid-group exit");
        disp_active = 1'b1;
        @(negedge clk);
        check_now("R9 restart at T0", 0, 1);
        @(negedge clk);
        check_now("R9 restart T1", 1, 1);
        end_display("R9 leave display");
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_unsplit();
        t_midgroup();
        t_cpu();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule